// File: doc/BRIEF.md
# Paired-Channel Conversion Result Readout Port

This block is the digital output stage of a six-channel converter whose channels are sampled in pairs. There are three start inputs, and each one owns a pair of channels. A rising edge on a start input while the block is idle arms that pair and starts a fixed-length conversion timer. A `busy` flag stays high while the timer runs. When the timer expires, the block latches the digital results of the armed channels from a flat input port. From then on, a host can read those results over a 16-bit parallel bus.

Reads are framed by an active-low chip select and an active-low read strobe. The host either holds chip select low and paces reads with the strobe alone, or pulses both together. Each completed read steps the block to the next item. The items come from converted channels only, in ascending channel number. In word mode each read carries one result, right-aligned with zero upper bits. In byte mode each result takes two reads on the upper bus byte. A static select input decides whether the high half or the low half comes first. The bus value is presented with a separate enable so that the pad ring can tri-state it.

Top module: `pair_conv_readout`

## Requirements
- R1: A rising edge on `start_a`, `start_b` or `start_c` while `busy` is low starts a conversion of channel pair {0,1}, {2,3} or {4,5} respectively. Edges that arrive in the same clock cycle are merged into one conversion.
- R2: `busy` goes high on the clock edge that samples the start edge. It stays high for exactly CLK_MHZ*CONV_NS/1000 cycles (600 with the defaults) and then falls.
- R3: A start edge that arrives while `busy` is high is ignored. It does not add a pair and does not extend the conversion.
- R4: Results are taken from `res_in` on the edge where `busy` falls. Channel c occupies bits [c*RES_W +: RES_W]. Later changes on `res_in` do not alter the values that are read.
- R5: In word mode (`byte_mode`=0), a sequence has two reads per converted pair. The reads return the converted channels in ascending order, each right-aligned on `bus_data` with the bits above RES_W at zero.
- R6: In byte mode (`byte_mode`=1), each channel takes two reads. Each read places one byte of the zero-extended 16-bit result on `bus_data[15:8]`, with `bus_data[7:0]` at zero. `hi_first`=1 gives the upper byte first, and `hi_first`=0 gives the lower byte first.
- R7: `bus_en` is high only while `cs_n` and `rd_n` are both low. Before any conversion has completed, a read returns zero.
- R8: The read position advances on a rising edge of `rd_n` while `cs_n` is low. A strobe made with `cs_n` high neither enables the bus nor advances.
- R9: Reads beyond the end of a sequence keep returning its last item.
- R10: Completion of a conversion replaces the set of readable channels and restarts the sequence at its first item. This happens even if a read advance falls on the same edge.
- R11: A new conversion may be started in the middle of a read sequence. Until it completes, reads continue through the previous sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_a | input | 1 | Start for channels 0 and 1 (rising edge) |
| start_b | input | 1 | Start for channels 2 and 3 (rising edge) |
| start_c | input | 1 | Start for channels 4 and 5 (rising edge) |
| res_in | input | 6*RES_W | Raw conversion results, channel c at [c*RES_W +: RES_W] |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_mode | input | 1 | 1: byte reads on upper bus byte, 0: word reads |
| hi_first | input | 1 | Byte mode: 1 upper byte first, 0 lower byte first |
| busy | output | 1 | High while a conversion is running |
| bus_data | output | 16 | Read data |
| bus_en | output | 1 | Bus output enable for the pad tri-state driver |

## Verification
Two events can land on the same clock edge: the end of a conversion, which resets the read position, and a read-strobe rising edge, which advances it. The bench provokes this by counting edges from a start pulse and releasing `rd_n` just before the edge on which `busy` falls. It then requires the next read to return the first item of the new sequence rather than the second. A second overlap is a start edge that arrives while a conversion is running. The bench judges this through the busy length and through the channels that come out.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  localparam int N_PAIR = 3;
  localparam int N_CH   = 2 * N_PAIR;

  typedef logic [N_PAIR-1:0] pair_mask_t;
  typedef logic [3:0]        rd_idx_t;
  typedef logic [2:0]        ch_idx_t;

  // k-th converted channel (ascending) for a given pair mask
  function automatic ch_idx_t nth_channel(input pair_mask_t pairs, input rd_idx_t k);
    rd_idx_t seen;
    ch_idx_t pick;
    seen = '0;
    pick = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (pairs[ch/2]) begin
        if (seen == k) pick = ch_idx_t'(ch);
        seen = seen + 1'b1;
      end
    end
    return pick;
  endfunction

  // number of reads in a full sequence
  function automatic rd_idx_t read_total(input pair_mask_t pairs, input logic byte_rd);
    rd_idx_t n;
    n = rd_idx_t'($countones(pairs)) << 1;
    return byte_rd ? (n << 1) : n;
  endfunction

  // byte chosen for read half `second` given the ordering select
  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic hi_sel,
                                           input logic second);
    return (hi_sel ^ second) ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/pcr_conv_timer.sv
module pcr_conv_timer
  import pcr_pkg::*;
#(
  parameter int CONV_CYC = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pair_mask_t start_lvl,
  output pair_mask_t start_rise,
  output pair_mask_t pend_mask,
  output logic       busy,
  output logic       eoc
);

  localparam int TW = $clog2(CONV_CYC + 1);

  pair_mask_t    start_q;
  logic [TW-1:0] timer_q;

  assign start_rise = start_lvl & ~start_q;
  assign eoc        = busy && (timer_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      timer_q   <= '0;
      busy      <= 1'b0;
      pend_mask <= '0;
    end else begin
      start_q <= start_lvl;
      if (!busy && (|start_rise)) begin
        busy      <= 1'b1;
        timer_q   <= TW'(CONV_CYC - 1);
        pend_mask <= start_rise;
      end else if (eoc) begin
        busy <= 1'b0;
      end else if (busy) begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcr_result_bank.sv
module pcr_result_bank
  import pcr_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eoc,
  input  pair_mask_t            pend_mask,
  input  logic [N_CH*RES_W-1:0] res_in,
  output logic [N_CH*RES_W-1:0] res_q
);

  localparam int PAIR_W = 2 * RES_W;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[p*PAIR_W +: PAIR_W] <= '0;
      end else if (eoc && pend_mask[p]) begin
        res_q[p*PAIR_W +: PAIR_W] <= res_in[p*PAIR_W +: PAIR_W];
      end
    end
  end

endmodule

// File: rtl/pcr_read_seq.sv
module pcr_read_seq
  import pcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       byte_mode,
  input  logic       eoc,
  input  pair_mask_t pend_mask,
  output pair_mask_t done_mask,
  output rd_idx_t    rd_idx,
  output rd_idx_t    total,
  output logic       rd_adv
);

  logic rd_q;

  assign total  = read_total(done_mask, byte_mode);
  assign rd_adv = rd_n && !rd_q && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b1;
      done_mask <= '0;
      rd_idx    <= '0;
    end else begin
      rd_q <= rd_n;
      if (eoc) begin
        done_mask <= pend_mask;
        rd_idx    <= '0;
      end else if (rd_adv && (rd_idx + 1'b1 < total)) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pair_conv_readout.sv
module pair_conv_readout
  import pcr_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int CLK_MHZ = 200,
  parameter int CONV_NS = 3000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_a,
  input  logic                  start_b,
  input  logic                  start_c,
  input  logic [6*RES_W-1:0]    res_in,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic                  byte_mode,
  input  logic                  hi_first,
  output logic                  busy,
  output logic [15:0]           bus_data,
  output logic                  bus_en
);

  localparam int CONV_CYC = (CLK_MHZ * CONV_NS) / 1000;

  pair_mask_t               start_rise;
  pair_mask_t               pend_mask;
  pair_mask_t               done_mask;
  logic                     eoc;
  logic                     rd_adv;
  rd_idx_t                  rd_idx;
  rd_idx_t                  total;
  logic [N_CH*RES_W-1:0]    res_q;
  rd_idx_t                  word_idx;
  ch_idx_t                  ch_sel;
  logic [RES_W-1:0]         res_sel;
  logic [15:0]              word16;
  logic [15:0]              bus_val;

  pcr_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_lvl  ({start_c, start_b, start_a}),
    .start_rise (start_rise),
    .pend_mask  (pend_mask),
    .busy       (busy),
    .eoc        (eoc)
  );

  pcr_result_bank #(.RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc       (eoc),
    .pend_mask (pend_mask),
    .res_in    (res_in),
    .res_q     (res_q)
  );

  pcr_read_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .byte_mode (byte_mode),
    .eoc       (eoc),
    .pend_mask (pend_mask),
    .done_mask (done_mask),
    .rd_idx    (rd_idx),
    .total     (total),
    .rd_adv    (rd_adv)
  );

  assign word_idx = byte_mode ? (rd_idx >> 1) : rd_idx;
  assign ch_sel   = nth_channel(done_mask, word_idx);
  assign res_sel  = res_q[ch_sel*RES_W +: RES_W];

  always_comb begin
    word16              = '0;
    word16[RES_W-1:0]   = res_sel;
    if (done_mask == '0)
      bus_val = '0;
    else if (byte_mode)
      bus_val = {pick_byte(word16, hi_first, rd_idx[0]), 8'h00};
    else
      bus_val = word16;
  end

  assign bus_en   = !cs_n && !rd_n;
  assign bus_data = bus_en ? bus_val : 16'h0000;

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int RES_W    = 16,
  parameter int CONV_CYC = 600
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        eoc,
  input logic [2:0]  start_rise,
  input logic [2:0]  pend_mask,
  input logic [3:0]  rd_idx,
  input logic [3:0]  total,
  input logic        rd_adv,
  input logic        cs_n,
  input logic        byte_mode,
  input logic [15:0] bus_data,
  input logic        bus_en
);

  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 1 : 32'd0;
  end

  p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|start_rise)) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(CONV_CYC)));

  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (|start_rise)) |=> $stable(pend_mask));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !byte_mode) |-> ((bus_data >> RES_W) == 16'h0000));

  p_byte_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && byte_mode) |-> (bus_data[7:0] == 8'h00));

  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !eoc) |=> $stable(rd_idx));

  p_last_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !eoc && (total != 4'd0) && (rd_idx == total - 4'd1)) |=> $stable(rd_idx));

  p_eoc_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (rd_idx == 4'd0));

endmodule

bind pair_conv_readout pcr_checker #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .eoc        (eoc),
  .start_rise (start_rise),
  .pend_mask  (pend_mask),
  .rd_idx     (rd_idx),
  .total      (total),
  .rd_adv     (rd_adv),
  .cs_n       (cs_n),
  .byte_mode  (byte_mode),
  .bus_data   (bus_data),
  .bus_en     (bus_en)
);

// File: tb/test_pair_conv_readout.sv
module test_pair_conv_readout;

  localparam int W    = 12;
  localparam int CONV = (200 * 3000) / 1000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     start_lvl = '0;
  logic [6*W-1:0] res_in = '0;
  logic           cs_n = 1'b1;
  logic           rd_n = 1'b1;
  logic           byte_mode = 1'b0;
  logic           hi_first = 1'b0;
  logic           busy;
  logic [15:0]    bus_data;
  logic           bus_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit cs_toggle = 0;
  logic [W-1:0] mdl [6];

  always #2.5 clk = ~clk;

  pair_conv_readout #(.RES_W(W), .CLK_MHZ(200), .CONV_NS(3000)) i_pair_conv_readout (
    .clk(clk), .rst_n(rst_n),
    .start_a(start_lvl[0]), .start_b(start_lvl[1]), .start_c(start_lvl[2]),
    .res_in(res_in), .cs_n(cs_n), .rd_n(rd_n),
    .byte_mode(byte_mode), .hi_first(hi_first),
    .busy(busy), .bus_data(bus_data), .bus_en(bus_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // expected bus value of read k in a sequence
  function automatic logic [15:0] exp_item(input logic [2:0] m, input int k,
                                           input logic bm, input logic hf);
    int lst[6];
    int n = 0;
    int tot, kk;
    logic [15:0] full;
    logic [7:0]  hi, lo;
    for (int p = 0; p < 3; p++)
      if (m[p]) begin lst[n] = 2*p; lst[n+1] = 2*p+1; n += 2; end
    if (n == 0) return 16'h0000;
    tot = bm ? 2*n : n;
    kk  = (k >= tot) ? tot - 1 : k;
    if (!bm) return {4'h0, mdl[lst[kk]]};
    full = {4'h0, mdl[lst[kk/2]]};
    hi = full[15:8];
    lo = full[7:0];
    if ((kk % 2 == 0) == hf) return {hi, 8'h00};
    return {lo, 8'h00};
  endfunction

  task automatic latch_model(input logic [2:0] m);
    for (int c = 0; c < 6; c++)
      if (m[c/2]) mdl[c] = res_in[c*W +: W];
  endtask

  task automatic read_one(output logic [15:0] v, output logic en);
    @(negedge clk);
    cs_n = 1'b0;
    rd_n = 1'b0;
    #1;
    v  = bus_data;
    en = bus_en;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    if (cs_toggle) cs_n = 1'b1;
  endtask

  task automatic start_and_wait(input logic [2:0] m, output int cnt);
    @(negedge clk);
    start_lvl = m;
    @(negedge clk);
    start_lvl = '0;
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    latch_model(m);
  endtask

  task automatic read_seq(input logic [2:0] m, input int nreads, input string tag);
    logic [15:0] v;
    logic en;
    for (int k = 0; k < nreads; k++) begin
      read_one(v, en);
      check(en && v == exp_item(m, k, byte_mode, hi_first), tag, v, exp_item(m, k, byte_mode, hi_first));
    end
  endtask

  task automatic set_res();
    for (int c = 0; c < 6; c++) res_in[c*W +: W] = W'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int cnt;
    logic [15:0] v;
    logic en;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(busy == 1'b0, "R2 reset busy", busy, 0);
    check(bus_en == 1'b0, "R7 idle bus_en", bus_en, 0);
    read_one(v, en);
    check(en && v == 16'h0000, "R7 empty read", v, 0);

    // R1 R2 R4 R5 R9: pairs A+B, word mode, cs held low
    cs_n = 1'b0;
    set_res();
    start_and_wait(3'b011, cnt);
    check(cnt == CONV, "R2 busy length", cnt, CONV);
    set_res();                                   // R4: later input changes ignored
    read_seq(3'b011, 6, "R5/R9/R4 word A+B");

    // R6 byte mode both orders, all six
    byte_mode = 1'b1;
    hi_first  = 1'b0;
    set_res();
    start_and_wait(3'b111, cnt);
    check(cnt == CONV, "R1 merged start busy", cnt, CONV);
    read_seq(3'b111, 13, "R6 byte lo-first");
    hi_first = 1'b1;
    set_res();
    start_and_wait(3'b101, cnt);
    read_seq(3'b101, 9, "R6 byte hi-first");
    byte_mode = 1'b0;

    // R3 start while busy ignored
    set_res();
    @(negedge clk); start_lvl = 3'b001;
    @(negedge clk); start_lvl = 3'b000;
    repeat (100) @(negedge clk);
    start_lvl = 3'b100;
    @(negedge clk); start_lvl = 3'b000;
    cnt = 102;
    while (busy && cnt < 5000) begin cnt++; @(negedge clk); end
    latch_model(3'b001);
    check(cnt == CONV + 1, "R3 busy not extended", cnt, CONV + 1);
    read_seq(3'b001, 3, "R3 only pair A");

    // R8 strobes with cs high do not enable or advance
    set_res();
    start_and_wait(3'b110, cnt);
    read_seq(3'b110, 1, "R8 first");
    cs_toggle = 1'b1;
    cs_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_n = 1'b0; #1;
      check(!bus_en && bus_data == 16'h0000, "R7/R8 cs high no bus", bus_data, 0);
      @(negedge clk); rd_n = 1'b1;
    end
    read_one(v, en);
    check(en && v == exp_item(3'b110, 1, 1'b0, hi_first), "R8 no advance", v, exp_item(3'b110, 1, 1'b0, hi_first));
    cs_toggle = 1'b0;

    // R11 start mid-sequence, old sequence continues during busy
    set_res();
    start_and_wait(3'b001, cnt);
    read_seq(3'b001, 1, "R11 before");
    @(negedge clk); start_lvl = 3'b100;
    @(negedge clk); start_lvl = 3'b000;
    read_one(v, en);
    check(busy == 1'b1, "R11 still busy", busy, 1);
    check(v == exp_item(3'b001, 1, 1'b0, hi_first), "R11 old item", v, exp_item(3'b001, 1, 1'b0, hi_first));
    while (busy) @(negedge clk);
    latch_model(3'b100);
    read_seq(3'b100, 2, "R11 new seq");

    // R10 read advance on the same edge as completion
    set_res();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; start_lvl = 3'b010;
    @(posedge clk);
    repeat (CONV - 1) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy before last edge", busy, 1);
    rd_n = 1'b1; start_lvl = 3'b000;
    @(negedge clk);
    check(busy == 1'b0, "R2 busy fell on time", busy, 0);
    latch_model(3'b010);
    read_seq(3'b010, 2, "R10 restart wins");

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [2:0] m;
      m = 3'($urandom_range(1, 7));
      byte_mode = 1'($urandom);
      hi_first  = 1'($urandom);
      cs_toggle = 1'($urandom);
      set_res();
      start_and_wait(m, cnt);
      check(cnt == CONV, "R2 random busy", cnt, CONV);
      read_seq(m, (byte_mode ? 4 : 2) * $countones(m) + 1, "R5/R6/R9 random");
    end

    finish_run();
  end

endmodule